// File: doc/BRIEF.md
# Graphics DRAM Power-Up Initialization Sequencer

This block sits in a memory controller and walks a graphics SDRAM from the moment its supplies and clock are stable to the point where it can be trained and used. It holds the device reset pin low with NOP on the command bus, then drives the clock-enable pin to the level that strapes the address/command termination. It also drives a width-select strap through the reset release. After that it waits out the long settle time, precharges all banks and writes the mode registers. It enables the write clock at the correct point among the mode-register writes, issues a pair of refreshes, and finally raises a sticky done flag.

All timing windows are cycle counts supplied on input ports. The mode-register contents come from inputs, each 16 bits wide, with the register index in bits [15:12] and the value in bits [11:0]. An optional address-training detour writes mode register 15 and then waits for an external completion level. A synchronous clear restarts the whole bring-up from the reset-hold phase.

Top module: `gddr_init_seq`

## Requirements
- R1: After the asynchronous reset, or in the cycle after `sync_clr_i`, the outputs are: `dram_rst_n_o`=0, `cke_n_o`=1, `strap_oe_o`=0, `wck_en_o`=0, `done_o`=0, `step_o`=0, no command valid. The reset-hold phase lasts at least `t_rst_i` cycles before the strap window opens.
- R2: `strap_oe_o` is high for exactly `t_ats_i` cycles with the reset pin low and then for `t_ath_i` cycles with it high. While it is high, `cke_n_o` equals `cke_term_i` and `edc_strap_o` equals `wide_i` (1 = 32-bit, 0 = 16-bit). After it falls, `cke_n_o` is 0.
- R3: The first command is PRECHARGE ALL, issued max(`t_init_i`−`t_ats_i`−`t_ath_i`, 1) + `t_ats_i` + `t_ath_i` + 2 cycles after the first strap-window cycle. Only NOPs precede it, so at least two NOP cycles come after the settle wait.
- R4: Command codes on `cmd_o` are 0 NOP, 1 PRECHARGE ALL, 2 MRS, 3 REFRESH. `cmd_vld_o` is high for one cycle exactly when `cmd_o` is not NOP.
- R5: The command after PRECHARGE ALL comes 1 + `t_rp_i` cycles after it.
- R6: With `train_en_i`=1, an MRS to register 15 carrying `mr15_i` follows the precharge. `atrain_req_o` is then high, with no command, until `train_done_i` is seen high and at least `t_mrd_i` cycles have passed. The vendor-ID MRS follows in the next cycle. With `train_en_i`=0 this step is skipped.
- R7: MRS order is `mr_vid_i`, then `mr_wckt_i`, then the `NUM_MR` entries of `mr_misc_i` from index 0 upward (entry i in bits [16i+15:16i]). Consecutive MRS are 1 + `t_mrd_i` cycles apart, and one extra cycle sits after the termination write.
- R8: `wck_en_o` rises 1 + `t_mrd_i` cycles after the write-clock termination MRS, one cycle before the first remaining MRS, and stays high.
- R9: Two REFRESH commands follow, the second 1 + `t_rfc_i` cycles after the last MRS's successor spacing. `done_o` rises 1 + `t_rfc_i` cycles after the second refresh with `step_o`=20, stays high, and no further commands appear.
- R10: `sync_clr_i` at any point returns the block to the R1 state on the next cycle and restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_clr_i | input | 1 | Synchronous restart of the bring-up |
| t_rst_i | input | TW | Reset-hold cycles |
| t_ats_i | input | TW | Strap setup cycles before reset release |
| t_ath_i | input | TW | Strap hold cycles after reset release |
| t_init_i | input | TW | Settle cycles counted from the strap setup start |
| t_rp_i | input | TW | Precharge recovery cycles |
| t_mrd_i | input | TW | Minimum MRS-to-MRS spacing |
| t_rfc_i | input | TW | Refresh recovery cycles |
| cke_term_i | input | 1 | Level strapped on clock-enable for termination |
| wide_i | input | 1 | Width strap: 1 = 32-bit, 0 = 16-bit |
| train_en_i | input | 1 | Enable address-training detour |
| train_done_i | input | 1 | Address training complete level |
| mr15_i | input | AD_W | Value written to register 15 |
| mr_vid_i | input | 16 | Vendor-ID read MRS {index, value} |
| mr_wckt_i | input | 16 | Write-clock termination MRS {index, value} |
| mr_misc_i | input | 16*NUM_MR | Remaining MRS entries |
| dram_rst_n_o | output | 1 | Device reset pin |
| cke_n_o | output | 1 | Device clock-enable pin (active low) |
| strap_oe_o | output | 1 | Strap window active |
| edc_strap_o | output | 1 | Width strap level |
| cmd_o | output | 3 | Command code |
| cmd_vld_o | output | 1 | One-cycle strobe for non-NOP commands |
| ba_o | output | 4 | Mode-register index for MRS |
| addr_o | output | AD_W | Mode-register value for MRS |
| wck_en_o | output | 1 | Write-clock enable |
| atrain_req_o | output | 1 | Address training in progress |
| done_o | output | 1 | Bring-up complete |
| step_o | output | 5 | Current step code |

## Verification
The hardest situations to reach are the training wait held open by a late completion and a restart in the middle of the mode-register writes, after the write clock is already on. The bench keeps `train_done_i` low for many cycles after `atrain_req_o` rises and checks that the bus stays quiet and the vendor MRS comes in the cycle after completion is seen. In a later run it waits for `wck_en_o` and then pulses `sync_clr_i` between two MRS commands. That run also picks a settle count smaller than setup plus hold, so the settle wait collapses to its one-cycle floor.

// File: rtl/gis_pkg.sv
package gis_pkg;

  localparam int unsigned BA_W     = 4;
  localparam int unsigned MRW      = 16;
  localparam int unsigned NOP_LEAD = 2;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_MRS  = 3'd2,
    CMD_REF  = 3'd3
  } cmd_e;

  typedef enum logic [4:0] {
    ST_RSTHOLD   = 5'd0,
    ST_SETUP     = 5'd1,
    ST_HOLD      = 5'd2,
    ST_SETTLE    = 5'd3,
    ST_NOPS      = 5'd4,
    ST_PREA      = 5'd5,
    ST_TRP       = 5'd6,
    ST_MR15      = 5'd7,
    ST_ATRAIN    = 5'd8,
    ST_MRS_VID   = 5'd9,
    ST_GAP_VID   = 5'd10,
    ST_MRS_WCKT  = 5'd11,
    ST_GAP_WCKT  = 5'd12,
    ST_WCK_ON    = 5'd13,
    ST_MRS_MISC  = 5'd14,
    ST_GAP_MISC  = 5'd15,
    ST_REF_A     = 5'd16,
    ST_RFC_A     = 5'd17,
    ST_REF_B     = 5'd18,
    ST_RFC_B     = 5'd19,
    ST_READY     = 5'd20
  } st_e;

endpackage

// File: rtl/gis_timer.sv
module gis_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic [TW-1:0] ld_val_i,
  output logic          expired_o
);

  logic [TW-1:0] cnt_q;
  logic          dec_en;

  assign dec_en = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (ld_i) begin
      cnt_q <= ld_val_i;
    end else if (dec_en) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // expires on the last cycle of the window (count 1) or when loaded with 0
  assign expired_o = (cnt_q[TW-1:1] == '0);

endmodule

// File: rtl/gis_seq_ctrl.sv
module gis_seq_ctrl
  import gis_pkg::*;
#(
  parameter int unsigned TW     = 16,
  parameter int unsigned NUM_MR = 4,
  localparam int unsigned IW    = (NUM_MR > 1) ? $clog2(NUM_MR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_clr_i,
  input  logic          train_en_i,
  input  logic          train_done_i,
  input  logic          expired_i,
  input  logic [TW-1:0] t_rst_i,
  input  logic [TW-1:0] t_ats_i,
  input  logic [TW-1:0] t_ath_i,
  input  logic [TW-1:0] t_init_i,
  input  logic [TW-1:0] t_rp_i,
  input  logic [TW-1:0] t_mrd_i,
  input  logic [TW-1:0] t_rfc_i,
  output st_e           state_d_o,
  output logic [IW-1:0] idx_d_o,
  output logic          ld_o,
  output logic [TW-1:0] ld_val_o
);

  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_MR - 1);

  st_e           state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          first_q;
  logic [TW:0]   strap_sum;
  logic [TW-1:0] settle_len;

  // remaining settle time once setup and hold are already spent
  assign strap_sum  = {1'b0, t_ats_i} + {1'b0, t_ath_i};
  assign settle_len = ({1'b0, t_init_i} > strap_sum) ? (t_init_i - strap_sum[TW-1:0])
                                                     : TW'(1);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_RSTHOLD:  if (!first_q && expired_i) state_d = ST_SETUP;
      ST_SETUP:    if (expired_i) state_d = ST_HOLD;
      ST_HOLD:     if (expired_i) state_d = ST_SETTLE;
      ST_SETTLE:   if (expired_i) state_d = ST_NOPS;
      ST_NOPS:     if (expired_i) state_d = ST_PREA;
      ST_PREA:     state_d = ST_TRP;
      ST_TRP:      if (expired_i) state_d = train_en_i ? ST_MR15 : ST_MRS_VID;
      ST_MR15:     state_d = ST_ATRAIN;
      ST_ATRAIN:   if (expired_i && train_done_i) state_d = ST_MRS_VID;
      ST_MRS_VID:  state_d = ST_GAP_VID;
      ST_GAP_VID:  if (expired_i) state_d = ST_MRS_WCKT;
      ST_MRS_WCKT: state_d = ST_GAP_WCKT;
      ST_GAP_WCKT: if (expired_i) state_d = ST_WCK_ON;
      ST_WCK_ON: begin
        state_d = ST_MRS_MISC;
        idx_d   = '0;
      end
      ST_MRS_MISC: state_d = ST_GAP_MISC;
      ST_GAP_MISC: begin
        if (expired_i) begin
          if (idx_q == LAST_IDX) begin
            state_d = ST_REF_A;
          end else begin
            state_d = ST_MRS_MISC;
            idx_d   = idx_q + 1'b1;
          end
        end
      end
      ST_REF_A:    state_d = ST_RFC_A;
      ST_RFC_A:    if (expired_i) state_d = ST_REF_B;
      ST_REF_B:    state_d = ST_RFC_B;
      ST_RFC_B:    if (expired_i) state_d = ST_READY;
      ST_READY:    state_d = ST_READY;
      default:     state_d = ST_RSTHOLD;
    endcase
    if (sync_clr_i) begin
      state_d = ST_RSTHOLD;
      idx_d   = '0;
    end
  end

  // the single down-counter is reloaded on every state entry
  assign ld_o = first_q | sync_clr_i | (state_d != state_q);

  always_comb begin
    unique case (state_d)
      ST_RSTHOLD:  ld_val_o = t_rst_i;
      ST_SETUP:    ld_val_o = t_ats_i;
      ST_HOLD:     ld_val_o = t_ath_i;
      ST_SETTLE:   ld_val_o = settle_len;
      ST_NOPS:     ld_val_o = TW'(NOP_LEAD);
      ST_TRP:      ld_val_o = t_rp_i;
      ST_ATRAIN,
      ST_GAP_VID,
      ST_GAP_WCKT,
      ST_GAP_MISC: ld_val_o = t_mrd_i;
      ST_RFC_A,
      ST_RFC_B:    ld_val_o = t_rfc_i;
      default:     ld_val_o = TW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RSTHOLD;
      idx_q   <= '0;
      first_q <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      first_q <= 1'b0;
    end
  end

  assign state_d_o = state_d;
  assign idx_d_o   = idx_d;

endmodule

// File: rtl/gis_bus_drv.sv
module gis_bus_drv
  import gis_pkg::*;
#(
  parameter int unsigned AD_W   = 12,
  parameter int unsigned NUM_MR = 4,
  localparam int unsigned IW    = (NUM_MR > 1) ? $clog2(NUM_MR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  st_e                   state_d_i,
  input  logic [IW-1:0]         idx_d_i,
  input  logic                  cke_term_i,
  input  logic                  wide_i,
  input  logic [AD_W-1:0]       mr15_i,
  input  logic [MRW-1:0]        mr_vid_i,
  input  logic [MRW-1:0]        mr_wckt_i,
  input  logic [NUM_MR*MRW-1:0] mr_misc_i,
  output logic                  dram_rst_n_o,
  output logic                  cke_n_o,
  output logic                  strap_oe_o,
  output logic                  edc_strap_o,
  output logic [2:0]            cmd_o,
  output logic                  cmd_vld_o,
  output logic [BA_W-1:0]       ba_o,
  output logic [AD_W-1:0]       addr_o,
  output logic                  wck_en_o,
  output logic                  atrain_req_o,
  output logic                  done_o,
  output logic [4:0]            step_o
);

  localparam logic [BA_W-1:0] TRAIN_MR = '1;

  logic            rst_n_d, cke_n_d, oe_d, strap_d, wck_d, atr_d, done_d;
  cmd_e            cmd_d;
  logic [BA_W-1:0] ba_d;
  logic [AD_W-1:0] addr_d;
  logic [MRW-1:0]  misc_sel;

  assign misc_sel = mr_misc_i[idx_d_i*MRW +: MRW];

  always_comb begin
    oe_d    = (state_d_i == ST_SETUP) || (state_d_i == ST_HOLD);
    rst_n_d = (state_d_i != ST_RSTHOLD) && (state_d_i != ST_SETUP);
    strap_d = oe_d & wide_i;
    if (state_d_i == ST_RSTHOLD) cke_n_d = 1'b1;
    else if (oe_d)               cke_n_d = cke_term_i;
    else                         cke_n_d = 1'b0;
    wck_d  = (state_d_i >= ST_WCK_ON);
    atr_d  = (state_d_i == ST_ATRAIN);
    done_d = (state_d_i == ST_READY);
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    unique case (state_d_i)
      ST_PREA:     cmd_d = CMD_PREA;
      ST_MR15: begin
        cmd_d  = CMD_MRS;
        ba_d   = TRAIN_MR;
        addr_d = mr15_i;
      end
      ST_MRS_VID: begin
        cmd_d  = CMD_MRS;
        ba_d   = mr_vid_i[MRW-1 -: BA_W];
        addr_d = mr_vid_i[AD_W-1:0];
      end
      ST_MRS_WCKT: begin
        cmd_d  = CMD_MRS;
        ba_d   = mr_wckt_i[MRW-1 -: BA_W];
        addr_d = mr_wckt_i[AD_W-1:0];
      end
      ST_MRS_MISC: begin
        cmd_d  = CMD_MRS;
        ba_d   = misc_sel[MRW-1 -: BA_W];
        addr_d = misc_sel[AD_W-1:0];
      end
      ST_REF_A, ST_REF_B: cmd_d = CMD_REF;
      default: cmd_d = CMD_NOP;
    endcase
  end

  // outputs registered from the next state so pins never carry decode glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_rst_n_o <= 1'b0;
      cke_n_o      <= 1'b1;
      strap_oe_o   <= 1'b0;
      edc_strap_o  <= 1'b0;
      cmd_o        <= CMD_NOP;
      cmd_vld_o    <= 1'b0;
      ba_o         <= '0;
      addr_o       <= '0;
      wck_en_o     <= 1'b0;
      atrain_req_o <= 1'b0;
      done_o       <= 1'b0;
      step_o       <= ST_RSTHOLD;
    end else begin
      dram_rst_n_o <= rst_n_d;
      cke_n_o      <= cke_n_d;
      strap_oe_o   <= oe_d;
      edc_strap_o  <= strap_d;
      cmd_o        <= cmd_d;
      cmd_vld_o    <= (cmd_d != CMD_NOP);
      ba_o         <= ba_d;
      addr_o       <= addr_d;
      wck_en_o     <= wck_d;
      atrain_req_o <= atr_d;
      done_o       <= done_d;
      step_o       <= state_d_i;
    end
  end

endmodule

// File: rtl/gddr_init_seq.sv
module gddr_init_seq
  import gis_pkg::*;
#(
  parameter int unsigned TW     = 16,
  parameter int unsigned NUM_MR = 4,
  parameter int unsigned AD_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sync_clr_i,
  input  logic [TW-1:0]         t_rst_i,
  input  logic [TW-1:0]         t_ats_i,
  input  logic [TW-1:0]         t_ath_i,
  input  logic [TW-1:0]         t_init_i,
  input  logic [TW-1:0]         t_rp_i,
  input  logic [TW-1:0]         t_mrd_i,
  input  logic [TW-1:0]         t_rfc_i,
  input  logic                  cke_term_i,
  input  logic                  wide_i,
  input  logic                  train_en_i,
  input  logic                  train_done_i,
  input  logic [AD_W-1:0]       mr15_i,
  input  logic [15:0]           mr_vid_i,
  input  logic [15:0]           mr_wckt_i,
  input  logic [NUM_MR*16-1:0]  mr_misc_i,
  output logic                  dram_rst_n_o,
  output logic                  cke_n_o,
  output logic                  strap_oe_o,
  output logic                  edc_strap_o,
  output logic [2:0]            cmd_o,
  output logic                  cmd_vld_o,
  output logic [3:0]            ba_o,
  output logic [AD_W-1:0]       addr_o,
  output logic                  wck_en_o,
  output logic                  atrain_req_o,
  output logic                  done_o,
  output logic [4:0]            step_o
);

  localparam int unsigned IW = (NUM_MR > 1) ? $clog2(NUM_MR) : 1;

  st_e           state_d;
  logic [IW-1:0] idx_d;
  logic          tmr_ld, tmr_exp;
  logic [TW-1:0] tmr_val;

  gis_seq_ctrl #(.TW(TW), .NUM_MR(NUM_MR)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_clr_i   (sync_clr_i),
    .train_en_i   (train_en_i),
    .train_done_i (train_done_i),
    .expired_i    (tmr_exp),
    .t_rst_i      (t_rst_i),
    .t_ats_i      (t_ats_i),
    .t_ath_i      (t_ath_i),
    .t_init_i     (t_init_i),
    .t_rp_i       (t_rp_i),
    .t_mrd_i      (t_mrd_i),
    .t_rfc_i      (t_rfc_i),
    .state_d_o    (state_d),
    .idx_d_o      (idx_d),
    .ld_o         (tmr_ld),
    .ld_val_o     (tmr_val)
  );

  gis_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_i      (tmr_ld),
    .ld_val_i  (tmr_val),
    .expired_o (tmr_exp)
  );

  gis_bus_drv #(.AD_W(AD_W), .NUM_MR(NUM_MR)) u_drv (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_d_i    (state_d),
    .idx_d_i      (idx_d),
    .cke_term_i   (cke_term_i),
    .wide_i       (wide_i),
    .mr15_i       (mr15_i),
    .mr_vid_i     (mr_vid_i),
    .mr_wckt_i    (mr_wckt_i),
    .mr_misc_i    (mr_misc_i),
    .dram_rst_n_o (dram_rst_n_o),
    .cke_n_o      (cke_n_o),
    .strap_oe_o   (strap_oe_o),
    .edc_strap_o  (edc_strap_o),
    .cmd_o        (cmd_o),
    .cmd_vld_o    (cmd_vld_o),
    .ba_o         (ba_o),
    .addr_o       (addr_o),
    .wck_en_o     (wck_en_o),
    .atrain_req_o (atrain_req_o),
    .done_o       (done_o),
    .step_o       (step_o)
  );

endmodule

// File: rtl/gis_checker.sv
module gis_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_clr_i,
  input logic       dram_rst_n_o,
  input logic       cke_n_o,
  input logic       strap_oe_o,
  input logic [2:0] cmd_o,
  input logic       cmd_vld_o,
  input logic       wck_en_o,
  input logic       atrain_req_o,
  input logic       done_o
);

  assert_vld_has_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |-> (cmd_o != 3'd0));

  assert_nop_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld_o |-> (cmd_o == 3'd0));

  assert_vld_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |=> !cmd_vld_o);

  assert_quiet_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_rst_n_o |-> !cmd_vld_o);

  assert_strap_at_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_rst_n_o) |-> (strap_oe_o && $stable(cke_n_o)));

  assert_cke_low_after_strap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_rst_n_o && !strap_oe_o) |-> !cke_n_o);

  assert_train_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    atrain_req_o |-> !cmd_vld_o);

  assert_wck_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wck_en_o |-> (dram_rst_n_o && !strap_oe_o));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !sync_clr_i) |=> done_o);

  assert_clr_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr_i |=> (!dram_rst_n_o && !done_o && !wck_en_o));

endmodule

bind gddr_init_seq gis_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sync_clr_i   (sync_clr_i),
  .dram_rst_n_o (dram_rst_n_o),
  .cke_n_o      (cke_n_o),
  .strap_oe_o   (strap_oe_o),
  .cmd_o        (cmd_o),
  .cmd_vld_o    (cmd_vld_o),
  .wck_en_o     (wck_en_o),
  .atrain_req_o (atrain_req_o),
  .done_o       (done_o)
);

// File: tb/gddr_init_seq_tb.sv
module gddr_init_seq_tb;

  localparam int TW = 16;
  localparam int NUM_MR = 4;
  localparam int AD_W = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, sync_clr = 1'b0;
  logic [TW-1:0] t_rst, t_ats, t_ath, t_init, t_rp, t_mrd, t_rfc;
  logic cke_term, wide, train_en, train_done;
  logic [AD_W-1:0] mr15;
  logic [15:0] mr_vid, mr_wckt;
  logic [NUM_MR*16-1:0] mr_misc;
  logic dram_rst_n, cke_n, strap_oe, edc_strap, cmd_vld, wck_en, atrain_req, done;
  logic [2:0] cmd;
  logic [3:0] ba;
  logic [AD_W-1:0] addr;
  logic [4:0] step;

  gddr_init_seq #(.TW(TW), .NUM_MR(NUM_MR), .AD_W(AD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_clr_i(sync_clr),
    .t_rst_i(t_rst), .t_ats_i(t_ats), .t_ath_i(t_ath), .t_init_i(t_init),
    .t_rp_i(t_rp), .t_mrd_i(t_mrd), .t_rfc_i(t_rfc),
    .cke_term_i(cke_term), .wide_i(wide), .train_en_i(train_en), .train_done_i(train_done),
    .mr15_i(mr15), .mr_vid_i(mr_vid), .mr_wckt_i(mr_wckt), .mr_misc_i(mr_misc),
    .dram_rst_n_o(dram_rst_n), .cke_n_o(cke_n), .strap_oe_o(strap_oe), .edc_strap_o(edc_strap),
    .cmd_o(cmd), .cmd_vld_o(cmd_vld), .ba_o(ba), .addr_o(addr), .wck_en_o(wck_en),
    .atrain_req_o(atrain_req), .done_o(done), .step_o(step)
  );

  typedef struct {
    logic [2:0] c;
    logic [3:0] b;
    logic [AD_W-1:0] a;
    int gap;
    string req;
  } item_t;

  item_t exp_q[$];
  int checks = 0, fails = 0;
  int cyc = 0, last_cyc = 0, rh = 0, ats_n = 0, ath_n = 0;
  int exp_gap_wck = 0, exp_gap_done = 0;
  logic prev_oe = 1'b0, prev_wck = 1'b0, prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [2:0] c, input logic [3:0] b, input logic [AD_W-1:0] a,
                      input int gap, input string req);
    item_t it;
    it.c = c; it.b = b; it.a = a; it.gap = gap; it.req = req;
    exp_q.push_back(it);
  endtask

  // monitor: pops expected commands and checks strap/clock/done timing
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!dram_rst_n && !strap_oe) rh++;
      if (strap_oe && !prev_oe) begin
        chk(rh >= int'(t_rst), "R1", "reset-hold cycles", rh, int'(t_rst));
        rh = 0; ats_n = 0; ath_n = 0; last_cyc = cyc;
      end
      if (strap_oe) begin
        if (!dram_rst_n) ats_n++; else ath_n++;
        chk(cke_n == cke_term && edc_strap == wide, "R2", "strap levels cke/edc",
            {cke_n, edc_strap}, {cke_term, wide});
      end
      if (!strap_oe && prev_oe) begin
        chk(ats_n == int'(t_ats), "R2", "setup cycles", ats_n, int'(t_ats));
        chk(ath_n == int'(t_ath), "R2", "hold cycles", ath_n, int'(t_ath));
        chk(cke_n == 1'b0, "R2", "cke after strap", cke_n, 0);
      end
      if (wck_en && !prev_wck)
        chk(cyc - last_cyc == exp_gap_wck, "R8", "wck enable gap", cyc - last_cyc, exp_gap_wck);
      if (done && !prev_done) begin
        chk(cyc - last_cyc == exp_gap_done, "R9", "done gap", cyc - last_cyc, exp_gap_done);
        chk(step == 5'd20, "R9", "step at done", step, 20);
      end
      if (cmd_vld) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", "unexpected command", cmd, 0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(cmd == e.c, e.req, "cmd code", cmd, e.c);
          if (e.c == 3'd2) begin
            chk(ba == e.b, e.req, "mrs index", ba, e.b);
            chk(addr == e.a, e.req, "mrs value", addr, e.a);
          end
          if (e.gap > 0) chk(cyc - last_cyc == e.gap, e.req, "command spacing", cyc - last_cyc, e.gap);
        end
        last_cyc = cyc;
      end
    end
    prev_oe = strap_oe; prev_wck = wck_en; prev_done = done;
  end

  task automatic load_sequence(input bit trn);
    int rem;
    rem = (int'(t_init) > int'(t_ats) + int'(t_ath)) ? int'(t_init) - int'(t_ats) - int'(t_ath) : 1;
    push(3'd1, 4'd0, '0, rem + int'(t_ats) + int'(t_ath) + 2, "R3");
    if (trn) begin
      push(3'd2, 4'd15, mr15, int'(t_rp) + 1, "R6");
      push(3'd2, mr_vid[15:12], mr_vid[11:0], 0, "R7");
    end else begin
      push(3'd2, mr_vid[15:12], mr_vid[11:0], int'(t_rp) + 1, "R5");
    end
    push(3'd2, mr_wckt[15:12], mr_wckt[11:0], int'(t_mrd) + 1, "R7");
    for (int i = 0; i < NUM_MR; i++)
      push(3'd2, mr_misc[16*i+12 +: 4], mr_misc[16*i +: 12],
           (i == 0) ? int'(t_mrd) + 2 : int'(t_mrd) + 1, "R7");
    push(3'd3, 4'd0, '0, int'(t_mrd) + 1, "R9");
    push(3'd3, 4'd0, '0, int'(t_rfc) + 1, "R9");
    exp_gap_wck  = int'(t_mrd) + 1;
    exp_gap_done = int'(t_rfc) + 1;
  endtask

  task automatic check_idle_state(input string req);
    chk(dram_rst_n == 0 && cke_n == 1 && strap_oe == 0, req, "reset pins", {dram_rst_n, cke_n, strap_oe}, 3'b010);
    chk(done == 0 && wck_en == 0 && cmd_vld == 0, req, "done/wck/vld", {done, wck_en, cmd_vld}, 0);
    chk(step == 5'd0, req, "step code", step, 0);
  endtask

  task automatic wait_done();
    for (int n = 0; n < 5000 && !done; n++) @(negedge clk);
    chk(done == 1'b1, "R9", "done reached", done, 1);
    chk(exp_q.size() == 0, "R7", "all commands seen", exp_q.size(), 0);
    repeat (20) @(negedge clk);
    chk(done == 1'b1 && cmd_vld == 1'b0, "R9", "done held, bus idle", {done, cmd_vld}, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_rst = 20; t_ats = 4; t_ath = 3; t_init = 30; t_rp = 5; t_mrd = 4; t_rfc = 9;
    cke_term = 1; wide = 1; train_en = 0; train_done = 0;
    mr15 = 12'h0A5; mr_vid = 16'h3123; mr_wckt = 16'h6456;
    mr_misc = {16'h2F0F, 16'h1ABC, 16'h5777, 16'h4001};

    // run 1: no training, 32-bit strap
    repeat (3) @(negedge clk);
    check_idle_state("R1");
    load_sequence(1'b0);
    rst_n = 1'b1;
    wait_done();

    // run 2: training detour held open, 16-bit strap
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    cke_term = 0; wide = 0; train_en = 1; t_init = 25;
    mr_misc = {16'h7111, 16'h8222, 16'h9333, 16'hA444};
    @(negedge clk);
    check_idle_state("R1");
    load_sequence(1'b1);
    rst_n = 1'b1;
    for (int n = 0; n < 2000 && !atrain_req; n++) @(negedge clk);
    chk(atrain_req == 1'b1, "R6", "training request", atrain_req, 1);
    repeat (15) begin
      @(negedge clk);
      chk(cmd_vld == 1'b0 && atrain_req == 1'b1, "R6", "quiet while training", {cmd_vld, atrain_req}, 1);
    end
    train_done = 1'b1;
    @(negedge clk);
    chk(cmd_vld && ba == mr_vid[15:12] && !atrain_req, "R6", "vendor MRS after training",
        {cmd_vld, ba, atrain_req}, {1'b1, mr_vid[15:12], 1'b0});
    wait_done();
    train_done = 1'b0;

    // run 3: restart mid-MRS, settle window collapses
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    cke_term = 1; wide = 0; train_en = 0; t_rst = 10;
    @(negedge clk);
    load_sequence(1'b0);
    rst_n = 1'b1;
    for (int n = 0; n < 2000 && !wck_en; n++) @(negedge clk);
    repeat (3) @(negedge clk);
    sync_clr = 1'b1;
    t_init = 2;
    @(negedge clk);
    sync_clr = 1'b0;
    exp_q.delete();
    rh = 1;
    check_idle_state("R10");
    load_sequence(1'b0);
    wait_done();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule